// File: doc/BRIEF.md
# Cascadable BCD Down-Counting Digit

This block holds one decimal digit of a countdown. It steps the digit down by one on each rising clock edge while its count enable is high. When it counts down from zero it returns to its highest value. A build-time parameter sets the modulus. Modulus 10 gives a units digit that runs 9 down to 0. Modulus 6 gives a tens-of-seconds digit that runs 5 down to 0.

There are two ways to force the digit to a value. An active-low clear drives it to zero at once, without waiting for a clock edge. An active-low load copies a 4-bit preset into the digit on the next rising edge.

Two flags come out of the block:
- A zero flag, which is high whenever the digit is zero.
- A terminal-count flag, which is high only when the digit is zero and the enable is high.

To build a multi-digit timer, connect each digit's terminal count to the enable of the next more significant digit. A minutes:seconds countdown then borrows correctly across every digit boundary.

Top module: `bcd_down_digit`

## Requirements
- R1: When `clr_n` is low, `digit` is 0 at once, with no clock edge needed. While `clr_n` stays low, `digit` stays 0.
- R2: When `load_n` is low at a rising edge (and `clr_n` is high), `digit` takes `load_val` on that edge. This happens whatever the level of `cnt_en`.
- R3: A `load_val` greater than MODULUS-1 loads as MODULUS-1. For modulus 10, values 10 to 15 load as 9. For modulus 6, values 6 to 15 load as 5.
- R4: When `load_n` is high, `cnt_en` is high and `digit` is not 0, `digit` decreases by exactly 1 on each rising edge.
- R5: When `load_n` is high, `cnt_en` is high and `digit` is 0, `digit` becomes MODULUS-1 (9 or 5) on the rising edge.
- R6: When `load_n` is high and `cnt_en` is low, `digit` keeps its value across rising edges.
- R7: `zero` is 1 exactly when `digit` is 0, whatever the level of `cnt_en`.
- R8: `tc` is 1 exactly when `digit` is 0 and `cnt_en` is 1.
- R9: Priority is fixed: clear first, then load, then count.
- R10: Chain three digits as follows. Seconds units (modulus 10) is enabled by the run signal. Seconds tens (modulus 6) is enabled by the `tc` of the seconds units. Minutes units (modulus 10) is enabled by the `tc` of the seconds tens. This chain counts 01:00, 00:59, and so on down to 00:00, then wraps to 09:59.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous preset strobe, active low |
| load_val | input | 4 | Preset value, clamped to MODULUS-1 |
| cnt_en | input | 1 | Count enable, active high |
| digit | output | 4 | Current BCD value |
| tc | output | 1 | Terminal count: zero and enabled |
| zero | output | 1 | Zero decode, independent of enable |

## Verification
The bench presets every 4-bit value into both a modulus-10 and a modulus-6 digit. A counter that stored an out-of-range preset as given would later show a digit such as 12 or 7, and the clamp checks would catch it.

Each preset is followed by a run of decrements long enough to pass through zero. A counter that wrapped to 15, or to the wrong top value, would break the borrow chain.

Two tests target priority. One lowers the clear between clock edges and checks that the digit is zero before any edge; a clear that waited for a clock edge would fail it. The other drives load and enable together; a design that let the enable win would show a decremented digit instead of the preset.

The cascade test steps through 600 seconds-and-minutes states. A terminal count that ignored the enable would make the tens and minutes digits decrement together with the units digit.

// File: rtl/bcd_dn_pkg.sv
package bcd_dn_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_DEC  = 2'd2,
        ACT_WRAP = 2'd3
    } step_act_e;

    typedef struct packed {
        logic zero;
        logic tc;
    } digit_flags_t;

    // Largest digit the chosen modulus can hold
    function automatic digit_t top_of(input int modulus);
        return digit_t'(modulus - 1);
    endfunction

    // Limit a preset to the legal range
    function automatic digit_t clamp_preset(input digit_t v, input digit_t top);
        return (v > top) ? top : v;
    endfunction

endpackage

// File: rtl/bcd_dn_next.sv
module bcd_dn_next
    import bcd_dn_pkg::*;
#(
    parameter int MODULUS = 10
) (
    input  digit_t    cur,
    input  logic      load_n,
    input  digit_t    load_val,
    input  logic      cnt_en,
    output step_act_e act,
    output digit_t    nxt
);
    localparam digit_t TOP = top_of(MODULUS);

    always_comb begin
        if (!load_n)          act = ACT_LOAD;
        else if (!cnt_en)     act = ACT_HOLD;
        else if (cur == '0)   act = ACT_WRAP;
        else                  act = ACT_DEC;
    end

    always_comb begin
        unique case (act)
            ACT_LOAD: nxt = clamp_preset(load_val, TOP);
            ACT_WRAP: nxt = TOP;
            ACT_DEC:  nxt = cur - digit_t'(1);
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/bcd_dn_flags.sv
module bcd_dn_flags
    import bcd_dn_pkg::*;
(
    input  digit_t       cur,
    input  logic         cnt_en,
    output digit_flags_t flags
);
    always_comb begin
        flags.zero = (cur == '0);
        flags.tc   = flags.zero & cnt_en;
    end
endmodule

// File: rtl/bcd_down_digit.sv
module bcd_down_digit
    import bcd_dn_pkg::*;
#(
    parameter int MODULUS = 10
) (
    input  logic       clk,
    input  logic       clr_n,
    input  logic       load_n,
    input  logic [3:0] load_val,
    input  logic       cnt_en,
    output logic [3:0] digit,
    output logic       tc,
    output logic       zero
);
    localparam digit_t TOP = top_of(MODULUS);

    digit_t       cnt_q;
    digit_t       cnt_d;
    step_act_e    act;
    digit_flags_t flg;

    bcd_dn_next #(.MODULUS(MODULUS)) u_next (
        .cur      (cnt_q),
        .load_n   (load_n),
        .load_val (load_val),
        .cnt_en   (cnt_en),
        .act      (act),
        .nxt      (cnt_d)
    );

    bcd_dn_flags u_flags (
        .cur    (cnt_q),
        .cnt_en (cnt_en),
        .flags  (flg)
    );

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign digit = cnt_q;
    assign tc    = flg.tc;
    assign zero  = flg.zero;

    // R4
    dec_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && digit != 4'd0) |=> (digit == $past(digit) - 4'd1));

    // R5
    wrap_top_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && digit == 4'd0) |=> (digit == TOP));

    // R6
    hold_idle_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !cnt_en) |=> $stable(digit));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!load_n && load_val <= TOP) |=> (digit == $past(load_val)));

    // R3
    load_clamp_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!load_n && load_val > TOP) |=> (digit == TOP));

    // R8
    tc_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
        tc |-> (cnt_en && zero));

    // R7
    zero_dec_chk: assert property (@(posedge clk) disable iff (!clr_n)
        zero == (digit == 4'd0));

    // R3
    digit_range_chk: assert property (@(posedge clk) disable iff (!clr_n)
        digit <= TOP);
endmodule

// File: tb/bcd_down_digit_test.sv
module bcd_down_digit_test;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int checks   = 0;
    int failures = 0;

    // shared controls for the single-digit units
    logic       clr_n = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] load_val = 4'd0;
    logic       cnt_en = 1'b0;

    logic [3:0] d10, d6;
    logic       tc10, tc6, z10, z6;

    bcd_down_digit #(.MODULUS(10)) uut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .load_val(load_val),
        .cnt_en(cnt_en), .digit(d10), .tc(tc10), .zero(z10));

    bcd_down_digit #(.MODULUS(6)) uut6 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .load_val(load_val),
        .cnt_en(cnt_en), .digit(d6), .tc(tc6), .zero(z6));

    // cascade: minutes units : seconds tens seconds units
    logic       c_load_n = 1'b1;
    logic       c_run = 1'b0;
    logic [3:0] c_m0_val = 4'd0, c_s1_val = 4'd0, c_s0_val = 4'd0;
    logic [3:0] s0, s1, m0;
    logic       s0_tc, s1_tc, m0_tc, s0_z, s1_z, m0_z;

    bcd_down_digit #(.MODULUS(10)) u_s0 (
        .clk(clk), .clr_n(clr_n), .load_n(c_load_n), .load_val(c_s0_val),
        .cnt_en(c_run), .digit(s0), .tc(s0_tc), .zero(s0_z));
    bcd_down_digit #(.MODULUS(6)) u_s1 (
        .clk(clk), .clr_n(clr_n), .load_n(c_load_n), .load_val(c_s1_val),
        .cnt_en(s0_tc), .digit(s1), .tc(s1_tc), .zero(s1_z));
    bcd_down_digit #(.MODULUS(10)) u_m0 (
        .clk(clk), .clr_n(clr_n), .load_n(c_load_n), .load_val(c_m0_val),
        .cnt_en(s1_tc), .digit(m0), .tc(m0_tc), .zero(m0_z));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int nxt_exp(input int cur, input int modulus);
        return (cur == 0) ? modulus - 1 : cur - 1;
    endfunction

    function automatic int clampv(input int v, input int modulus);
        return (v > modulus - 1) ? modulus - 1 : v;
    endfunction

    initial begin
        #(200_000 * 4);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int e10, e6, tot;
        #1;
        // R1 R7 R8: reset state
        chk("R1 d10 under clear", int'(d10), 0);
        chk("R1 d6 under clear", int'(d6), 0);
        chk("R7 zero under clear", int'(z10), 1);
        chk("R8 tc with enable low", int'(tc10), 0);
        step();
        clr_n = 1'b1;

        // R2 R3 R4 R5 R7 R8: every preset, then count through zero
        for (int v = 0; v < 16; v++) begin
            load_n = 1'b0; load_val = 4'(v); cnt_en = 1'b0;
            step();
            e10 = clampv(v, 10);
            e6  = clampv(v, 6);
            chk("R2/R3 load mod10", int'(d10), e10);
            chk("R2/R3 load mod6", int'(d6), e6);
            load_n = 1'b1; cnt_en = 1'b1;
            for (int k = 0; k < 12; k++) begin
                #0;
                chk("R7 zero mod10", int'(z10), int'(e10 == 0));
                chk("R8 tc mod6", int'(tc6), int'(e6 == 0));
                step();
                e10 = nxt_exp(e10, 10);
                e6  = nxt_exp(e6, 6);
                chk("R4/R5 count mod10", int'(d10), e10);
                chk("R4/R5 count mod6", int'(d6), e6);
            end
        end

        // R6: hold with enable low
        cnt_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R6 hold mod10", int'(d10), e10);
            chk("R6 hold mod6", int'(d6), e6);
        end

        // R7 R8: zero with enable low, tc stays low
        load_n = 1'b0; load_val = 4'd0;
        step();
        load_n = 1'b1;
        chk("R7 zero without enable", int'(z10), 1);
        chk("R8 tc gated by enable", int'(tc10), 0);
        cnt_en = 1'b1; #1;
        chk("R8 tc when enabled", int'(tc10), 1);

        // R9: load wins over count
        load_n = 1'b0; load_val = 4'd3; cnt_en = 1'b1;
        step();
        chk("R9 load over count mod10", int'(d10), 3);
        chk("R9 load over count mod6", int'(d6), 3);

        // R1: async clear between edges
        load_n = 1'b1; cnt_en = 1'b0;
        #1 clr_n = 1'b0;
        #0.5;
        chk("R1 async clear mod10", int'(d10), 0);
        chk("R1 async clear mod6", int'(d6), 0);
        // R9: clear over load
        load_n = 1'b0; load_val = 4'd7; cnt_en = 1'b1;
        step();
        chk("R9 clear over load", int'(d10), 0);
        clr_n = 1'b1; load_n = 1'b1; cnt_en = 1'b0;
        step();

        // R10: cascade 01:00 -> 00:59 -> ... wrap to 09:59
        c_load_n = 1'b0; c_m0_val = 4'd1; c_s1_val = 4'd0; c_s0_val = 4'd0;
        step();
        c_load_n = 1'b1;
        tot = 60;
        chk("R10 preset 01:00", int'(m0) * 60 + int'(s1) * 10 + int'(s0), tot);
        c_run = 1'b1;
        step();
        chk("R10 first borrow m0", int'(m0), 0);
        chk("R10 first borrow s1", int'(s1), 5);
        chk("R10 first borrow s0", int'(s0), 9);
        tot = 59;
        for (int k = 0; k < 600; k++) begin
            step();
            tot = (tot == 0) ? 599 : tot - 1;
            chk("R10 cascade value",
                int'(m0) * 60 + int'(s1) * 10 + int'(s0), tot);
        end
        c_run = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule